// File: doc/BRIEF.md
# I2C Primary Transaction Engine

This block runs the primary (master) side of an I2C bus, one bus step per command. The caller issues a start condition, a byte write, a byte read or a stop condition through a single-cycle command strobe. The engine drives SCL and SDA through open-drain style enables: a high enable pulls the line low, and a low enable lets the line float high. It samples SDA through a short synchronizer. The commands are `start`, `write`, `read` and `stop`. A read carries a flag that answers the byte with NACK instead of ACK, which is how the final byte of a read is closed.

The clock is set by a half-period counter. Each half period lasts 8 + RATE·N input clocks, where N is 1, 4, 16 or 64 as chosen by a 2-bit prescaler select. A full SCL period is therefore 16 + 2·RATE·N clocks. The engine reports `busy` while a step runs. When the step ends, it posts a 4-bit status code that describes how that step went. The code tells an address byte apart from a data byte, a write address from a read address, and an ACK from a NACK.

Top module: `i2c_host_engine`

## Requirements
- R1: After reset, `busy` is 0, `scl_oe` and `sda_oe` are 0 (both lines released) and `status` is 0x0.
- R2: Every half period lasts 8 + RATE·N clocks, where N = 1, 4, 16, 64 for `presc` = 0, 1, 2, 3. While a byte moves, SCL falls every 16 + 2·RATE·N clocks. SCL never changes while the engine is not busy.
- R3: A `start` command (`cmd_op` = 0) on a released bus pulls SDA low while SCL is high and then pulls SCL low. It takes 2 half periods and ends with status 0x1. When the bus is already held, the same command first releases SDA and then SCL, and then makes the same SDA-then-SCL fall. That repeated start takes 4 half periods and also ends with 0x1.
- R4: A `write` command (`cmd_op` = 1) sends `cmd_byte` MSB first over 8 SCL pulses. It then releases SDA for a ninth pulse and takes SDA low at the end of that pulse's high phase as ACK. It takes 18 half periods.
- R5: The first `write` after a start is the address byte. Its bit 0 gives the direction. The status for a write ending is then one of the following:
  - address with bit 0 = 0: 0x2 on ACK, 0x3 on NACK;
  - address with bit 0 = 1: 0x6 on ACK, 0x7 on NACK;
  - any later write (a data byte): 0x4 on ACK, 0x5 on NACK.
- R6: A `read` command (`cmd_op` = 2) releases SDA for 8 pulses and shifts the line in MSB first at the end of each high phase. On the ninth pulse it drives ACK (low), or NACK (released) when `cmd_nack` is 1. It then presents the byte on `rx_data` with status 0x8 (ACK sent) or 0x9 (NACK sent). It takes 18 half periods.
- R7: A `stop` command (`cmd_op` = 3) pulls SDA low while SCL is low, then releases SCL, then releases SDA while SCL is high. This leaves both lines released. It takes 3 half periods and ends with status 0xA.
- R8: SDA changes while SCL is high only inside a start or stop condition. Every other SDA change comes at least one clock after SCL has fallen.
- R9: A command that arrives while `busy` is 1 is ignored. `status` and `rx_data` change only on the clock edge where `busy` falls.
- R10: A `write`, `read` or `stop` issued while no start is in effect (bus not held) is ignored. `busy` stays 0, both lines stay released and `status` keeps its value.
- R11: The rate and prescaler values are captured when a command is accepted. Changing them while `busy` is 1 does not alter the running step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate | input | 8 | Bit-rate value RATE |
| presc | input | 2 | Prescaler select (N = 4^presc) |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_byte | input | 8 | Byte to send with a write |
| cmd_nack | input | 1 | Read: answer the byte with NACK |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A bus step is running |
| status | output | 4 | Outcome code of the last finished step |
| rx_data | output | 8 | Last byte read |

## Verification
The assertions assume that reset is applied at time zero and that `sda_in` is the real wired-AND of the engine's SDA enable and a secondary that changes its drive only while SCL is low. The SDA checks rest on that assumption, because a secondary that changes SDA while SCL is high would look like an illegal start or stop. The bench models that secondary. It changes its drive half a clock after each SCL fall, and it holds SDA released during start and stop. The bench holds the command strobe below the length of a step, so the ignored commands in R9 never slip into the idle cycle that follows.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_STOP  = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      ST_NONE    = 4'h0,
      ST_START   = 4'h1,
      ST_AW_ACK  = 4'h2,
      ST_AW_NACK = 4'h3,
      ST_TX_ACK  = 4'h4,
      ST_TX_NACK = 4'h5,
      ST_AR_ACK  = 4'h6,
      ST_AR_NACK = 4'h7,
      ST_RX_ACK  = 4'h8,
      ST_RX_NACK = 4'h9,
      ST_STOP    = 4'hA
   } stat_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_START,
      PH_BIT,
      PH_STOP
   } seq_e;

   // {scl_low, sda_low} for each half period of a start; a fresh start enters at 2
   function automatic logic [1:0] start_lv(input logic [1:0] s);
      case (s)
         2'd0:    start_lv = 2'b10;
         2'd1:    start_lv = 2'b00;
         2'd2:    start_lv = 2'b01;
         default: start_lv = 2'b11;
      endcase
   endfunction

   // {scl_low, sda_low} for each half period of a stop
   function automatic logic [1:0] stop_lv(input logic [1:0] s);
      case (s)
         2'd0:    stop_lv = 2'b11;
         2'd1:    stop_lv = 2'b01;
         default: stop_lv = 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/i2c_host_rate.sv
module i2c_host_rate #(
   parameter int RATE_W   = 8,
   parameter int PSC_W    = 2,
   parameter int PSC_STEP = 2,
   parameter int CNT_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   input  logic [PSC_W-1:0]  presc,
   output logic              tick
);
   localparam int BASE_HALF = 8;

   logic [CNT_W-1:0] half_d, half_q, cnt_q;

   // half period = 8 + rate * 2^(PSC_STEP*presc)
   assign half_d = CNT_W'(BASE_HALF) + (CNT_W'(rate) << (PSC_STEP * presc));
   assign tick   = run && (cnt_q == half_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= CNT_W'(BASE_HALF);
         cnt_q  <= '0;
      end else begin
         if (load) half_q <= half_d;
         if (!run || tick) cnt_q <= '0;
         else              cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/i2c_host_sync.sv
module i2c_host_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_thru
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '1;
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_host_seq.sv
module i2c_host_seq
   import i2c_host_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_byte,
   input  logic              cmd_nack,
   input  logic              tick,
   input  logic              sda_s,
   output logic              accept,
   output logic              busy,
   output logic              scl_low,
   output logic              sda_low,
   output logic [3:0]        status,
   output logic [DATA_W-1:0] rx_data
);
   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [BIT_W-1:0] ACK_BIT = BIT_W'(DATA_W);

   seq_e              state;
   logic [1:0]        step;
   logic [BIT_W-1:0]  bit_k;
   logic              high_ph, is_read, nack_q, held, addr_pend, dir_rd;
   logic              scl_q, sda_tgt, sda_q;
   logic [DATA_W-1:0] shreg, rx_q;
   stat_e             stat_q, done_st;
   logic              ack_seen;

   assign busy    = (state != PH_IDLE);
   assign accept  = cmd_valid && !busy && ((cmd_op == OP_START) || held);
   assign scl_low = scl_q;
   assign sda_low = sda_q;
   assign status  = stat_q;
   assign rx_data = rx_q;

   assign ack_seen = !sda_s;

   always_comb begin
      if (is_read)        done_st = nack_q ? ST_RX_NACK : ST_RX_ACK;
      else if (!addr_pend) done_st = ack_seen ? ST_TX_ACK : ST_TX_NACK;
      else if (dir_rd)    done_st = ack_seen ? ST_AR_ACK : ST_AR_NACK;
      else                done_st = ack_seen ? ST_AW_ACK : ST_AW_NACK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PH_IDLE;
         step      <= '0;
         bit_k     <= '0;
         high_ph   <= 1'b0;
         is_read   <= 1'b0;
         nack_q    <= 1'b0;
         held      <= 1'b0;
         addr_pend <= 1'b0;
         dir_rd    <= 1'b0;
         scl_q     <= 1'b0;
         sda_tgt   <= 1'b0;
         sda_q     <= 1'b0;
         shreg     <= '0;
         rx_q      <= '0;
         stat_q    <= ST_NONE;
      end else begin
         // SDA follows its target one clock late, so it never moves on an SCL edge
         sda_q <= sda_tgt;
         case (state)
            PH_IDLE: begin
               if (accept) begin
                  case (cmd_op)
                     OP_START: begin
                        state            <= PH_START;
                        step             <= held ? 2'd0 : 2'd2;
                        {scl_q, sda_tgt} <= start_lv(held ? 2'd0 : 2'd2);
                     end
                     OP_WRITE: begin
                        state   <= PH_BIT;
                        shreg   <= cmd_byte;
                        is_read <= 1'b0;
                        dir_rd  <= cmd_byte[0];
                        bit_k   <= '0;
                        high_ph <= 1'b0;
                        sda_tgt <= !cmd_byte[DATA_W-1];
                     end
                     OP_READ: begin
                        state   <= PH_BIT;
                        is_read <= 1'b1;
                        nack_q  <= cmd_nack;
                        bit_k   <= '0;
                        high_ph <= 1'b0;
                        sda_tgt <= 1'b0;
                     end
                     default: begin
                        state            <= PH_STOP;
                        step             <= 2'd0;
                        {scl_q, sda_tgt} <= stop_lv(2'd0);
                     end
                  endcase
               end
            end
            PH_START: begin
               if (tick) begin
                  if (step == 2'd3) begin
                     state     <= PH_IDLE;
                     held      <= 1'b1;
                     addr_pend <= 1'b1;
                     stat_q    <= ST_START;
                  end else begin
                     step             <= step + 2'd1;
                     {scl_q, sda_tgt} <= start_lv(step + 2'd1);
                  end
               end
            end
            PH_STOP: begin
               if (tick) begin
                  if (step == 2'd2) begin
                     state  <= PH_IDLE;
                     held   <= 1'b0;
                     stat_q <= ST_STOP;
                  end else begin
                     step             <= step + 2'd1;
                     {scl_q, sda_tgt} <= stop_lv(step + 2'd1);
                  end
               end
            end
            default: begin
               if (tick) begin
                  if (!high_ph) begin
                     high_ph <= 1'b1;
                     scl_q   <= 1'b0;
                  end else begin
                     high_ph <= 1'b0;
                     scl_q   <= 1'b1;
                     if (bit_k == ACK_BIT) begin
                        state  <= PH_IDLE;
                        stat_q <= done_st;
                        if (is_read) rx_q <= shreg;
                        else         addr_pend <= 1'b0;
                     end else begin
                        shreg <= {shreg[DATA_W-2:0], is_read ? sda_s : 1'b0};
                        bit_k <= bit_k + BIT_W'(1);
                        if (bit_k == ACK_BIT - BIT_W'(1))
                           sda_tgt <= is_read ? !nack_q : 1'b0;
                        else
                           sda_tgt <= is_read ? 1'b0 : !shreg[DATA_W-2];
                     end
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/i2c_host_engine.sv
module i2c_host_engine
   import i2c_host_pkg::*;
#(
   parameter int RATE_W      = 8,
   parameter int PSC_W       = 2,
   parameter int PSC_STEP    = 2,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   input  logic [PSC_W-1:0]  presc,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_byte,
   input  logic              cmd_nack,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              busy,
   output logic [3:0]        status,
   output logic [DATA_W-1:0] rx_data
);
   localparam int MAX_SHIFT = PSC_STEP * ((1 << PSC_W) - 1);
   localparam int NEED_W    = RATE_W + MAX_SHIFT + 1;

   generate
      if (CNT_W < NEED_W) begin : g_bad_cnt
         $error("CNT_W too narrow for the largest half period");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic tick, accept, sda_s;

   i2c_host_rate #(
      .RATE_W(RATE_W), .PSC_W(PSC_W), .PSC_STEP(PSC_STEP), .CNT_W(CNT_W)
   ) u_rate (
      .clk(clk), .rst_n(rst_n), .load(accept), .run(busy),
      .rate(rate), .presc(presc), .tick(tick)
   );

   i2c_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   i2c_host_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .tick(tick), .sda_s(sda_s),
      .accept(accept), .busy(busy), .scl_low(scl_oe), .sda_low(sda_oe),
      .status(status), .rx_data(rx_data)
   );
endmodule

// File: rtl/i2c_host_chk.sv
module i2c_host_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              scl_oe,
   input logic              sda_oe,
   input logic [3:0]        status,
   input logic [DATA_W-1:0] rx_data
);
   // R2: SCL holds still whenever the engine is idle
   a_r2_scl_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(scl_oe));

   // R8: an SDA change while SCL stays high happens only inside a running step
   a_r8_sda_high_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe))) |-> busy);

   // R9: the status code stays put while a step runs
   a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(status));

   // R9: the read byte only updates as a step ends
   a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> ($past(busy) && !busy));

   // R7: once a stop completes both lines are released
   a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && status == 4'hA) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_host_engine i2c_host_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .status(status), .rx_data(rx_data)
);

// File: tb/i2c_host_engine_bench.sv
module i2c_host_engine_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rate = 8'd0;
   logic [1:0] presc = 2'd0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [7:0] cmd_byte = 8'd0;
   logic       cmd_nack = 1'b0;
   logic       scl_oe, sda_oe, busy;
   logic [3:0] status;
   logic [7:0] rx_data;

   // secondary model: drives low where its bit is 0, indexed by SCL falls since issue
   logic [8:0] sl_bits = 9'h1FF;
   int         fall_cnt = 0, fall_base = 0, sl_idx;
   logic       sl_drive, sda_line;
   assign sl_idx   = fall_cnt - fall_base;
   assign sl_drive = (sl_idx >= 0 && sl_idx < 9) ? !sl_bits[8 - sl_idx] : 1'b0;
   assign sda_line = !(sda_oe || sl_drive);

   i2c_host_engine u_i2c_host_engine (
      .clk(clk), .rst_n(rst_n), .rate(rate), .presc(presc),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
      .cmd_nack(cmd_nack), .sda_in(sda_line), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .busy(busy), .status(status), .rx_data(rx_data)
   );

   always #4 clk = !clk;

   int   cyc = 0, last_fall_t = 0, period = 0, start_cnt = 0, stop_cnt = 0;
   logic prev_scl_oe = 1'b0, prev_sda = 1'b1;
   logic [8:0] cap = '0;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (scl_oe && !prev_scl_oe) begin
         fall_cnt    <= fall_cnt + 1;
         period      <= cyc - last_fall_t;
         last_fall_t <= cyc;
      end
      if (!scl_oe && prev_scl_oe) cap <= {cap[7:0], sda_line};
      if (!scl_oe && !prev_scl_oe && rst_n) begin
         if (prev_sda && !sda_line) start_cnt <= start_cnt + 1;
         if (!prev_sda && sda_line) stop_cnt <= stop_cnt + 1;
      end
      prev_scl_oe <= scl_oe;
      prev_sda    <= sda_line;
   end

   int checks = 0, failures = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int half_of(input logic [7:0] r, input logic [1:0] p);
      return 8 + int'(r) * (1 << (2 * int'(p)));
   endfunction

   task automatic run_cmd(input logic [1:0] op, input logic [7:0] b, input logic nk,
                          input logic [8:0] sb, output int dur);
      @(negedge clk);
      sl_bits   = sb;
      fall_base = fall_cnt;
      cmd_op    = op;
      cmd_byte  = b;
      cmd_nack  = nk;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      dur = 0;
      while (busy && dur < 5000) begin
         dur++;
         @(negedge clk);
      end
   endtask

   typedef struct packed {
      logic [1:0] op;
      logic [7:0] byt;
      logic       nack;
      logic [7:0] rate;
      logic [1:0] psc;
      logic [8:0] sbits;
      logic [3:0] st;
      logic [4:0] halves;
      logic [7:0] rx;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 8'h00, 1'b0, 8'd2, 2'd0, 9'h1FF, 4'h1, 5'd2,  8'h00}, // R3 fresh start
      '{2'd1, 8'hA4, 1'b0, 8'd2, 2'd0, 9'h1FE, 4'h2, 5'd18, 8'h00}, // R5 addr W ack
      '{2'd1, 8'h11, 1'b0, 8'd1, 2'd1, 9'h1FE, 4'h4, 5'd18, 8'h00}, // R5 data ack
      '{2'd1, 8'h3C, 1'b0, 8'd0, 2'd0, 9'h1FF, 4'h5, 5'd18, 8'h00}, // R5 data nack
      '{2'd0, 8'h00, 1'b0, 8'd0, 2'd0, 9'h1FF, 4'h1, 5'd4,  8'h00}, // R3 repeated
      '{2'd1, 8'hA5, 1'b0, 8'd2, 2'd0, 9'h1FE, 4'h6, 5'd18, 8'h00}, // R5 addr R ack
      '{2'd2, 8'h00, 1'b0, 8'd1, 2'd2, 9'h12D, 4'h8, 5'd18, 8'h96}, // R6 read ack
      '{2'd2, 8'h00, 1'b1, 8'd3, 2'd0, 9'h0B5, 4'h9, 5'd18, 8'h5A}, // R6 read nack
      '{2'd3, 8'h00, 1'b0, 8'd1, 2'd3, 9'h1FF, 4'hA, 5'd3,  8'h00}, // R7 stop
      '{2'd0, 8'h00, 1'b0, 8'd3, 2'd0, 9'h1FF, 4'h1, 5'd2,  8'h00}, // R3 fresh start
      '{2'd1, 8'h40, 1'b0, 8'd3, 2'd0, 9'h1FF, 4'h3, 5'd18, 8'h00}, // R5 addr W nack
      '{2'd0, 8'h00, 1'b0, 8'd3, 2'd0, 9'h1FF, 4'h1, 5'd4,  8'h00}, // R3 repeated
      '{2'd1, 8'h41, 1'b0, 8'd3, 2'd0, 9'h1FF, 4'h7, 5'd18, 8'h00}, // R5 addr R nack
      '{2'd3, 8'h00, 1'b0, 8'd0, 2'd0, 9'h1FF, 4'hA, 5'd3,  8'h00}  // R7 stop
   };

   initial begin : watchdog
      while (cyc < 150000 && !done) @(negedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int dur, h;
      logic [3:0] st_before;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines", {scl_oe, sda_oe}, 0);
      chk(status == 4'h0, "R1 status", status, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         rate  = VEC[i].rate;
         presc = VEC[i].psc;
         h     = half_of(VEC[i].rate, VEC[i].psc);
         run_cmd(VEC[i].op, VEC[i].byt, VEC[i].nack, VEC[i].sbits, dur);
         chk(dur == int'(VEC[i].halves) * h, "R2 step length", dur, int'(VEC[i].halves) * h);
         chk(status == VEC[i].st, "R5 status code", status, VEC[i].st);
         if (VEC[i].op == 2'd1) begin
            chk(cap == {VEC[i].byt, VEC[i].sbits[0]}, "R4 bits on SDA", cap, {VEC[i].byt, VEC[i].sbits[0]});
            chk(period == 2 * h, "R2 SCL period", period, 2 * h);
         end
         if (VEC[i].op == 2'd2) begin
            chk(rx_data == VEC[i].rx, "R6 read byte", rx_data, VEC[i].rx);
            chk(cap == {VEC[i].rx, VEC[i].nack}, "R6 ack bit", cap, {VEC[i].rx, VEC[i].nack});
            chk(period == 2 * h, "R2 SCL period", period, 2 * h);
         end
         if (VEC[i].op == 2'd3)
            chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 lines released", {scl_oe, sda_oe}, 0);
      end

      // R10: write with no start in effect is ignored
      st_before = status;
      run_cmd(2'd1, 8'hFF, 1'b0, 9'h1FF, dur);
      repeat (4) begin
         chk(busy == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R10 ignored cmd",
             {busy, scl_oe, sda_oe}, 0);
         @(negedge clk);
      end
      chk(status == st_before, "R10 status kept", status, st_before);

      // R9 and R11: stop requested while busy, rate changed mid-step
      rate = 8'd5; presc = 2'd0;
      @(negedge clk);
      sl_bits = 9'h1FF; fall_base = fall_cnt;
      cmd_op = 2'd0; cmd_valid = 1'b1;
      @(negedge clk);
      rate = 8'd0; cmd_op = 2'd3;
      dur = 0;
      while (busy && dur < 5000) begin
         dur++;
         if (dur == 10) cmd_valid = 1'b0;
         @(negedge clk);
      end
      chk(dur == 26, "R11 captured rate", dur, 26);
      chk(status == 4'h1, "R9 busy blocks", status, 1);
      run_cmd(2'd3, 8'h00, 1'b0, 9'h1FF, dur);
      chk(dur == 24, "R7 stop length", dur, 24);
      chk(status == 4'hA, "R7 stop status", status, 4'hA);
      repeat (2) @(negedge clk);
      // R8: SDA moved with SCL high only for starts and stops
      chk(start_cnt == 5, "R8 start events", start_cnt, 5);
      chk(stop_cnt == 3, "R8 stop events", stop_cnt, 3);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule